// File: doc/BRIEF.md
# Frame-Based Receive Gain Control

This block sits in a digital receive path and levels a stream of 16-bit signed I/Q samples one frame at a time. Each sample passes through a power-of-two shifter whose direction and amount come from a 4-bit sign-magnitude gain code. Results that leave the 16-bit range are saturated, and each such sample is counted as an overflow. While the frame runs, the block also tracks the largest pre-gain component magnitude.

A frame-end strobe closes the frame. On that clock edge the block publishes an 8-bit peak level and an 8-bit overflow count, and then clears its accumulators. When gain control is enabled, the same edge moves the gain. Any clipping cuts the gain at once by the attack step. A weak frame raises the gain by the decay step, but only once the holdoff counter has run down to zero. A frame whose level is in range leaves the gain unchanged and restarts the holdoff.

The sample path has no storage. The output valid follows the input valid, and the input ready follows the output ready in the same cycle, so back-pressure from downstream reaches the source without delay. A sample is transferred, and counted in the statistics, only in a cycle where both valid and ready are high.

Top module: `rx_frame_agc`

## Requirements
- R1: The gain code has bit 3 as the direction (0 selects a left shift, which amplifies; 1 selects an arithmetic right shift, which attenuates) and bits 2:0 as the shift amount. With code 0 the output sample equals the input sample.
- R2: The internal signed gain always stays within -7 to +7. Results of attack and decay steps are clamped to that range, so code 0x7 is the largest gain and code 0xF is the strongest attenuation.
- R3: After shifting, each component saturates to the range -32768 to 32767. A sample adds one to the overflow count if its I component, its Q component or both went out of range.
- R4: The overflow count of a frame stops at 255.
- R5: The peak is taken before gain as the largest value of max(|I|,|Q|) over the frame. A magnitude of 32768 is treated as 32767. The peak is reported as that 15-bit magnitude shifted right by 7. A sample accepted in the same cycle as the frame-end strobe belongs to the frame that is closing. Both accumulators start from zero for the next frame.
- R6: At a frame end while enabled, a nonzero overflow count lowers the gain by the attack input (clamped) and reloads the holdoff counter from the holdoff input.
- R7: At a frame end while enabled, with no overflow and a peak below the target input: if the holdoff counter is zero, the gain rises by the decay input (clamped); otherwise the counter decrements and the gain is held.
- R8: At a frame end while enabled, with no overflow and a peak at or above the target, the gain is held and the holdoff counter is reloaded.
- R9: On the first cycle that the enable input is high after being low, the gain becomes 0 and the holdoff counter loads the holdoff input. This takes precedence over a frame-end update in the same cycle.
- R10: While the enable input is low, the gain and the holdoff counter are frozen, and the stored gain still drives the shifter. Peak and overflow reports are still produced at every frame end.
- R11: The gain code stays constant for the whole of a frame. A new gain applies from the first cycle after the frame-end edge.
- R12: `m_valid` equals `s_valid` and `s_ready` equals `m_ready` in the same cycle. A sample offered while `m_ready` is low is not taken and does not affect the statistics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample ready |
| s_i | input | 16 | Input I, signed |
| s_q | input | 16 | Input Q, signed |
| frame_end | input | 1 | Frame-close strobe |
| agc_en | input | 1 | Gain control enable |
| cfg_target | input | 8 | Peak level target |
| cfg_attack | input | 4 | Gain-down step on clipping |
| cfg_decay | input | 4 | Gain-up step on weak frames |
| cfg_holdoff | input | 4 | Weak frames to wait before gain-up |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Output sample ready |
| m_i | output | 16 | Shifted I, signed |
| m_q | output | 16 | Shifted Q, signed |
| gain_code | output | 4 | Current sign-magnitude gain code |
| peak_level | output | 8 | Peak of the last closed frame |
| sat_count | output | 8 | Overflow count of the last closed frame |

## Verification
The bench uses the default parameters: 16-bit samples, an 8-bit peak and 4-bit step and holdoff fields. With these widths a shift of 7 pushes a moderate input far past the 16-bit range, so both ends of the ±7 clamp can be reached within a few frames. A 300-sample clipping frame is enough to reach the 255 cap on the overflow count. The 8-bit peak, which covers the top 8 bits of a 15-bit magnitude, lets the most-negative input show the 32768-to-32767 magnitude clamp as a report of 255.

// File: rtl/rx_agc_pkg.sv
package rx_agc_pkg;
  localparam int GAIN_W     = 4;
  localparam int GAIN_LIMIT = 7;
  typedef logic [GAIN_W-1:0] gain_code_t;
endpackage

// File: rtl/rx_agc_shift_lane.sv
module rx_agc_shift_lane
  import rx_agc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  gain_code_t                 code,
  input  logic signed [DATA_W-1:0]   din,
  output logic signed [DATA_W-1:0]   dout,
  output logic                       ovf
);
  localparam int EW = DATA_W + 8;
  localparam logic signed [EW-1:0] HI_LIM = {{(EW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [EW-1:0] LO_LIM = {{(EW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [EW-1:0] ext;
  logic signed [EW-1:0] wide;
  logic                 too_hi;
  logic                 too_lo;

  always_comb begin
    ext = {{(EW-DATA_W){din[DATA_W-1]}}, din};
    if (code[GAIN_W-1]) wide = ext >>> code[GAIN_W-2:0];
    else                wide = ext <<< code[GAIN_W-2:0];
    too_hi = wide > HI_LIM;
    too_lo = wide < LO_LIM;
    ovf    = too_hi | too_lo;
    if (too_hi)      dout = HI_LIM[DATA_W-1:0];
    else if (too_lo) dout = LO_LIM[DATA_W-1:0];
    else             dout = wide[DATA_W-1:0];
  end
endmodule

// File: rtl/rx_agc_stats.sv
module rx_agc_stats #(
  parameter int DATA_W = 16,
  parameter int PEAK_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic signed [DATA_W-1:0] din_i,
  input  logic signed [DATA_W-1:0] din_q,
  input  logic                     ovf,
  input  logic                     frame_end,
  output logic [PEAK_W-1:0]        frame_peak,
  output logic                     frame_sat_nz,
  output logic [PEAK_W-1:0]        peak_o,
  output logic [CNT_W-1:0]         sat_o
);
  localparam int MAG_W = DATA_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [MAG_W-1:0] peak_acc, peak_run, mag_i, mag_q, cur_mag;
  logic [CNT_W-1:0] cnt_acc, cnt_run;

  function automatic logic [MAG_W-1:0] mag_of(input logic signed [DATA_W-1:0] v);
    logic signed [DATA_W-1:0] n;
    n = -v;
    if (!v[DATA_W-1])                  return v[MAG_W-1:0];
    else if (v == {1'b1, {MAG_W{1'b0}}}) return '1;
    else                               return n[MAG_W-1:0];
  endfunction

  always_comb begin
    mag_i        = mag_of(din_i);
    mag_q        = mag_of(din_q);
    cur_mag      = take ? ((mag_i > mag_q) ? mag_i : mag_q) : '0;
    peak_run     = (cur_mag > peak_acc) ? cur_mag : peak_acc;
    cnt_run      = (take && ovf && cnt_acc != CNT_MAX) ? cnt_acc + 1'b1 : cnt_acc;
    frame_peak   = peak_run[MAG_W-1 -: PEAK_W];
    frame_sat_nz = cnt_run != '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      peak_acc <= '0;
      cnt_acc  <= '0;
      peak_o   <= '0;
      sat_o    <= '0;
    end else if (frame_end) begin
      peak_acc <= '0;
      cnt_acc  <= '0;
      peak_o   <= frame_peak;
      sat_o    <= cnt_run;
    end else begin
      peak_acc <= peak_run;
      cnt_acc  <= cnt_run;
    end
  end

  p_peak_report_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (peak_o == $past(frame_peak)));
  p_sat_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && cnt_acc == CNT_MAX) |=> (cnt_acc == CNT_MAX));
endmodule

// File: rtl/rx_agc_ctrl.sv
module rx_agc_ctrl
  import rx_agc_pkg::*;
#(
  parameter int PEAK_W = 8,
  parameter int STEP_W = 4,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              agc_en,
  input  logic              frame_end,
  input  logic [PEAK_W-1:0] frame_peak,
  input  logic              frame_sat_nz,
  input  logic [PEAK_W-1:0] cfg_target,
  input  logic [STEP_W-1:0] cfg_attack,
  input  logic [STEP_W-1:0] cfg_decay,
  input  logic [HOLD_W-1:0] cfg_holdoff,
  output gain_code_t        gain_code_o
);
  localparam int SUM_W = STEP_W + GAIN_W;
  localparam logic signed [SUM_W-1:0] LIM_HI = SUM_W'(GAIN_LIMIT);
  localparam logic signed [SUM_W-1:0] LIM_LO = -LIM_HI;

  logic signed [GAIN_W-1:0] gain_q, gain_d, gain_neg;
  logic [HOLD_W-1:0]        hold_q, hold_d;
  logic                     en_q, rise;
  logic signed [SUM_W-1:0]  gain_ext, step_dn, step_up;

  function automatic logic signed [GAIN_W-1:0] clamp_g(input logic signed [SUM_W-1:0] v);
    if (v > LIM_HI)      return LIM_HI[GAIN_W-1:0];
    else if (v < LIM_LO) return LIM_LO[GAIN_W-1:0];
    else                 return v[GAIN_W-1:0];
  endfunction

  always_comb begin
    rise     = agc_en & ~en_q;
    gain_ext = {{(SUM_W-GAIN_W){gain_q[GAIN_W-1]}}, gain_q};
    step_dn  = gain_ext - $signed({{(SUM_W-STEP_W){1'b0}}, cfg_attack});
    step_up  = gain_ext + $signed({{(SUM_W-STEP_W){1'b0}}, cfg_decay});
    gain_d   = gain_q;
    hold_d   = hold_q;
    if (rise) begin
      gain_d = '0;
      hold_d = cfg_holdoff;
    end else if (agc_en && frame_end) begin
      if (frame_sat_nz) begin
        gain_d = clamp_g(step_dn);
        hold_d = cfg_holdoff;
      end else if (frame_peak < cfg_target) begin
        if (hold_q == '0) gain_d = clamp_g(step_up);
        else              hold_d = hold_q - 1'b1;
      end else begin
        hold_d = cfg_holdoff;
      end
    end
    gain_neg    = -gain_q;
    gain_code_o = gain_q[GAIN_W-1] ? {1'b1, gain_neg[GAIN_W-2:0]}
                                   : {1'b0, gain_q[GAIN_W-2:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= '0;
      hold_q <= '0;
      en_q   <= 1'b0;
    end else begin
      gain_q <= gain_d;
      hold_q <= hold_d;
      en_q   <= agc_en;
    end
  end

  p_gain_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q <= 4'sd7) && (gain_q >= -4'sd7));
  p_enable_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_en && !en_q) |=> (gain_q == '0 && hold_q == $past(cfg_holdoff)));
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !agc_en |=> ($stable(gain_q) && $stable(hold_q)));
  p_code_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !(agc_en && !en_q)) |=> $stable(gain_code_o));
  p_attack_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && agc_en && en_q && frame_sat_nz) |=> (hold_q == $past(cfg_holdoff)));
endmodule

// File: rtl/rx_frame_agc.sv
module rx_frame_agc
  import rx_agc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PEAK_W = 8,
  parameter int CNT_W  = 8,
  parameter int STEP_W = 4,
  parameter int HOLD_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic signed [DATA_W-1:0] s_i,
  input  logic signed [DATA_W-1:0] s_q,
  input  logic                     frame_end,
  input  logic                     agc_en,
  input  logic [PEAK_W-1:0]        cfg_target,
  input  logic [STEP_W-1:0]        cfg_attack,
  input  logic [STEP_W-1:0]        cfg_decay,
  input  logic [HOLD_W-1:0]        cfg_holdoff,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic signed [DATA_W-1:0] m_i,
  output logic signed [DATA_W-1:0] m_q,
  output logic [GAIN_W-1:0]        gain_code,
  output logic [PEAK_W-1:0]        peak_level,
  output logic [CNT_W-1:0]         sat_count
);
  localparam int LANES = 2;
  localparam logic signed [DATA_W-1:0] OUT_HI = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] OUT_LO = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] lane_in  [LANES];
  logic signed [DATA_W-1:0] lane_out [LANES];
  logic [LANES-1:0]         lane_ovf;
  logic                     take;
  logic [PEAK_W-1:0]        frame_peak;
  logic                     frame_sat_nz;

  assign s_ready    = m_ready;
  assign m_valid    = s_valid;
  assign take       = s_valid & m_ready;
  assign lane_in[0] = s_i;
  assign lane_in[1] = s_q;
  assign m_i        = lane_out[0];
  assign m_q        = lane_out[1];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    rx_agc_shift_lane #(.DATA_W(DATA_W)) u_lane (
      .code (gain_code),
      .din  (lane_in[k]),
      .dout (lane_out[k]),
      .ovf  (lane_ovf[k])
    );
  end

  rx_agc_stats #(.DATA_W(DATA_W), .PEAK_W(PEAK_W), .CNT_W(CNT_W)) u_stats (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .din_i        (s_i),
    .din_q        (s_q),
    .ovf          (|lane_ovf),
    .frame_end    (frame_end),
    .frame_peak   (frame_peak),
    .frame_sat_nz (frame_sat_nz),
    .peak_o       (peak_level),
    .sat_o        (sat_count)
  );

  rx_agc_ctrl #(.PEAK_W(PEAK_W), .STEP_W(STEP_W), .HOLD_W(HOLD_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .agc_en       (agc_en),
    .frame_end    (frame_end),
    .frame_peak   (frame_peak),
    .frame_sat_nz (frame_sat_nz),
    .cfg_target   (cfg_target),
    .cfg_attack   (cfg_attack),
    .cfg_decay    (cfg_decay),
    .cfg_holdoff  (cfg_holdoff),
    .gain_code_o  (gain_code)
  );

  p_unity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_code == '0) |-> (m_i == s_i && m_q == s_q));
  p_clip_rail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_ovf) |-> (m_i == OUT_HI || m_i == OUT_LO || m_q == OUT_HI || m_q == OUT_LO));
endmodule

// File: tb/rx_frame_agc_tb_top.sv
module rx_frame_agc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  typedef struct packed {
    logic signed [15:0] i;
    logic signed [15:0] q;
    logic signed [15:0] ei;
    logic signed [15:0] eq;
    logic [7:0]         pk;
    logic [7:0]         sat;
    logic [3:0]         code;
  } vec_t;

  // one-sample frames, target 200, attack 2, decay 3, holdoff 1; code is the value after the frame
  localparam vec_t TBL [NVEC] = '{
    '{16'sd1000,   16'sd0,      16'sd1000,   16'sd0,      8'd7,   8'd0, 4'h0},
    '{16'sd1000,   16'sd0,      16'sd1000,   16'sd0,      8'd7,   8'd0, 4'h3},
    '{16'sd1000,   16'sd0,      16'sd8000,   16'sd0,      8'd7,   8'd0, 4'h6},
    '{16'sd1000,   16'sd0,      16'sd32767,  16'sd0,      8'd7,   8'd1, 4'h4},
    '{-16'sd3000,  16'sd0,      -16'sd32768, 16'sd0,      8'd23,  8'd1, 4'h2},
    '{16'sd30000,  16'sd0,      16'sd32767,  16'sd0,      8'd234, 8'd1, 4'h0},
    '{16'sd30000,  16'sd0,      16'sd30000,  16'sd0,      8'd234, 8'd0, 4'h0},
    '{-16'sd32768, 16'sd0,      -16'sd32768, 16'sd0,      8'd255, 8'd0, 4'h0},
    '{16'sd30000,  -16'sd31000, 16'sd30000,  -16'sd31000, 8'd242, 8'd0, 4'h0},
    '{16'sd100,    16'sd0,      16'sd100,    16'sd0,      8'd0,   8'd0, 4'h0},
    '{16'sd100,    16'sd0,      16'sd100,    16'sd0,      8'd0,   8'd0, 4'h3},
    '{16'sd100,    16'sd0,      16'sd800,    16'sd0,      8'd0,   8'd0, 4'h6},
    '{16'sd100,    16'sd0,      16'sd6400,   16'sd0,      8'd0,   8'd0, 4'h7},
    '{16'sd100,    16'sd0,      16'sd12800,  16'sd0,      8'd0,   8'd0, 4'h7},
    '{16'sd20000,  16'sd0,      16'sd32767,  16'sd0,      8'd156, 8'd1, 4'h5},
    '{16'sd20000,  16'sd0,      16'sd32767,  16'sd0,      8'd156, 8'd1, 4'h3},
    '{16'sd20000,  16'sd0,      16'sd32767,  16'sd0,      8'd156, 8'd1, 4'h1},
    '{16'sd20000,  16'sd0,      16'sd32767,  16'sd0,      8'd156, 8'd1, 4'h9},
    '{16'sd20000,  16'sd0,      16'sd10000,  16'sd0,      8'd156, 8'd0, 4'h9},
    '{-16'sd3,     16'sd0,      -16'sd2,     16'sd0,      8'd0,   8'd0, 4'h2}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic s_valid, s_ready, frame_end, agc_en, m_valid, m_ready;
  logic signed [15:0] s_i, s_q, m_i, m_q;
  logic [7:0] cfg_target, peak_level, sat_count;
  logic [3:0] cfg_attack, cfg_decay, cfg_holdoff, gain_code;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_agc dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .frame_end(frame_end), .agc_en(agc_en),
    .cfg_target(cfg_target), .cfg_attack(cfg_attack), .cfg_decay(cfg_decay),
    .cfg_holdoff(cfg_holdoff), .m_valid(m_valid), .m_ready(m_ready),
    .m_i(m_i), .m_q(m_q), .gain_code(gain_code), .peak_level(peak_level),
    .sat_count(sat_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; drives, checks the combinational output, steps one cycle
  task automatic beat(input logic signed [15:0] i, input logic signed [15:0] q,
                      input logic fe, input logic vld,
                      input bit chk_out, input logic signed [15:0] ei,
                      input logic signed [15:0] eq, input string tag);
    s_i = i; s_q = q; s_valid = vld; frame_end = fe;
    #1;
    if (chk_out) begin
      chk({tag, " m_i"}, int'(m_i), int'(ei));
      chk({tag, " m_q"}, int'(m_q), int'(eq));
    end
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0; frame_end = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; frame_end = 1'b0; agc_en = 1'b0; m_ready = 1'b1;
    s_i = '0; s_q = '0;
    cfg_target = 8'd200; cfg_attack = 4'd2; cfg_decay = 4'd3; cfg_holdoff = 4'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("reset gain_code", int'(gain_code), 0);
    chk("reset peak_level", int'(peak_level), 0);
    chk("reset sat_count", int'(sat_count), 0);

    // R12: back-pressure; offered sample is not taken
    m_ready = 1'b0;
    s_valid = 1'b1; s_i = 16'sd30000; s_q = 16'sd0; frame_end = 1'b1;
    #1;
    chk("R12 s_ready low", int'(s_ready), 0);
    chk("R12 m_valid follows", int'(m_valid), 1);
    @(posedge clk); @(negedge clk);
    s_valid = 1'b0; frame_end = 1'b0; m_ready = 1'b1;
    chk("R12 stalled sample not counted", int'(peak_level), 0);
    #1;
    chk("R12 s_ready follows", int'(s_ready), 1);
    @(negedge clk);

    // R9: enable edge
    agc_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 gain zero on enable", int'(gain_code), 0);

    // table walk: R1 R2 R3 R6 R7 R8 R11
    for (int k = 0; k < NVEC; k++) begin
      beat(TBL[k].i, TBL[k].q, 1'b1, 1'b1, 1'b1, TBL[k].ei, TBL[k].eq,
           $sformatf("R1/R3 vec%0d", k));
      chk($sformatf("R5 vec%0d peak", k), int'(peak_level), int'(TBL[k].pk));
      chk($sformatf("R3 vec%0d sat", k), int'(sat_count), int'(TBL[k].sat));
      chk($sformatf("R6/R7/R8/R2 vec%0d code", k), int'(gain_code), int'(TBL[k].code));
    end

    // R4 + R2: long clipping frame, big attack clamps to -7
    cfg_attack = 4'd15;
    for (int n = 0; n < 300; n++)
      beat(16'sd32767, 16'sd32767, (n == 299), 1'b1, (n == 0), 16'sd32767, 16'sd32767, "R3 clip");
    chk("R4 sat cap", int'(sat_count), 255);
    chk("R5 peak full", int'(peak_level), 255);
    chk("R2 clamp low code", int'(gain_code), 15);
    cfg_attack = 4'd2;

    // R1: strongest attenuation, arithmetic shift of the most negative input
    beat(-16'sd32768, 16'sd0, 1'b1, 1'b1, 1'b1, -16'sd256, 16'sd0, "R1 atten7");
    chk("R8 hold at -7", int'(gain_code), 15);

    // R10: disabled, weak frame, gain frozen, stats still reported
    agc_en = 1'b0;
    beat(16'sd1000, 16'sd0, 1'b1, 1'b1, 1'b1, 16'sd7, 16'sd0, "R10 stored gain applies");
    chk("R10 frozen code", int'(gain_code), 15);
    chk("R10 peak reported", int'(peak_level), 7);
    chk("R10 sat reported", int'(sat_count), 0);

    // R9: re-enable resets gain and reloads holdoff
    agc_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 re-enable code", int'(gain_code), 0);
    beat(16'sd100, 16'sd0, 1'b1, 1'b1, 1'b0, 16'sd0, 16'sd0, "R7 w1");
    chk("R7 holdoff wait", int'(gain_code), 0);
    beat(16'sd100, 16'sd0, 1'b1, 1'b1, 1'b0, 16'sd0, 16'sd0, "R7 w2");
    chk("R7 step up", int'(gain_code), 3);

    // R11 + R5: multi-sample frame, clip mid-frame, gain unchanged until the end
    beat(16'sd500, 16'sd0, 1'b0, 1'b1, 1'b1, 16'sd4000, 16'sd0, "R11 s0");
    beat(-16'sd9000, 16'sd0, 1'b0, 1'b1, 1'b1, -16'sd32768, 16'sd0, "R11 s1");
    chk("R11 code constant mid-frame", int'(gain_code), 3);
    beat(16'sd3000, 16'sd0, 1'b1, 1'b1, 1'b1, 16'sd24000, 16'sd0, "R11 s2");
    chk("R5 frame peak", int'(peak_level), 70);
    chk("R6 frame sat", int'(sat_count), 1);
    chk("R11 code after end", int'(gain_code), 1);

    // R5: empty frame reports zero after clear
    beat(16'sd0, 16'sd0, 1'b1, 1'b0, 1'b0, 16'sd0, 16'sd0, "R5 empty");
    chk("R5 cleared peak", int'(peak_level), 0);
    chk("R5 cleared sat", int'(sat_count), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule